// File: doc/BRIEF.md
# Three-Level Reset Sequencer

This controller produces the chip's reset sequence from six sources. It has three reset levels: power-on, hard and soft. It samples a power-on request pin, two open-drain reset pins (hard and soft), two internal expiry events (watchdog and bus monitor) and a soft-reset request from a test access port. From these it drives the reset levels to the clock synthesizer, the processor cores and the peripherals. It also drives the strobes that capture two configuration words.

Each open-drain pin is modelled as two signals. One is a pull-down enable output: a 1 pulls the pin low. The other is the sampled level of the pin, returned as an input. The controller cannot tell its own pull-down from an external one. For that reason it ignores the pin it is driving, and it keeps ignoring that pin until its released level has passed through the synchronizer.

When a higher-level request arrives during a sequence, the sequence restarts at that level. A request at the same or a lower level is ignored. When the stretch count ends, the controller releases the outputs one per cycle in this order:
1. the hard pin
2. the soft pin
3. the core and peripheral resets

Top module: `reset_sequencer`

## Requirements
- R1: The power-on pin (active low) must read low for at least POR_MIN_CYC (16) consecutive synchronized cycles before it is accepted. A shorter low pulse changes no output.
- R2: An accepted power-on reset does all of the following: asserts the clock-synthesizer reset (low), pulls down both reset pins, asserts the core and peripheral resets (low), and strobes both configuration captures.
- R3: The power-on configuration word is captured only during a power-on sequence. Hard and soft sequences leave it unchanged.
- R4: Each of these starts a hard sequence: an external low on the hard pin, a watchdog expiry with its enable set, or a bus-monitor expiry with its enable set. A hard sequence pulls down both pins, resets the cores and peripherals and recaptures the 32-bit hard configuration word. It leaves the clock-synthesizer reset deasserted. An expiry whose enable is clear is ignored.
- R5: Whenever the hard pin is pulled down, the soft pin is pulled down too.
- R6: A test-port request or an external low on the soft pin starts a soft sequence. A soft sequence pulls down only the soft pin and resets only the cores. Both configuration words keep their values.
- R7: An external low on the soft pin is recognized only when the controller is idle. The controller's own release of a pin never starts a new sequence.
- R8: Once a sequence's request has ended, the hard pin stays pulled down for exactly STRETCH_CYC (16) cycles in a hard or power-on sequence. In every sequence the soft pin stays pulled down for STRETCH_CYC+1 cycles.
- R9: Release order: the hard pin first, the soft pin one cycle later, then the core and peripheral resets one cycle after that.
- R10: A higher-level request during a sequence restarts the sequence at that level, with a fresh stretch count. A same-level or lower-level request is ignored.
- R11: Timing to the first output change: an internal event is seen one clock edge after it is sampled, and an external pin change is seen on the third edge (two-flop synchronizer plus one state register).
- R12: While rst_n is low, the controller holds a power-on-level sequence. After rst_n is released it completes the stretch count and releases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset of the controller |
| por_in_n | input | 1 | Asynchronous power-on request, active low |
| hard_pin_in_n | input | 1 | Sampled level of the open-drain hard-reset pin |
| soft_pin_in_n | input | 1 | Sampled level of the open-drain soft-reset pin |
| wdog_expire | input | 1 | Watchdog count reached zero (synchronous) |
| wdog_en | input | 1 | Enables watchdog-initiated hard reset |
| bmon_expire | input | 1 | Bus-monitor count reached zero (synchronous) |
| bmon_en | input | 1 | Enables bus-monitor-initiated hard reset |
| tap_soft_req | input | 1 | Soft-reset request from the test access port |
| pcfg_pins | input | PCFG_W | Power-on configuration pins |
| hcw_in | input | HCW_W | Hard-reset configuration word source |
| hard_pin_pd | output | 1 | Pull-down enable of the hard-reset pin |
| soft_pin_pd | output | 1 | Pull-down enable of the soft-reset pin |
| pll_rst_n | output | 1 | Clock-synthesizer state reset, active low |
| core_rst_n | output | 1 | Processor core reset, active low |
| periph_rst_n | output | 1 | Peripheral reset, active low |
| pcfg_stb | output | 1 | Power-on configuration capture strobe |
| hcw_stb | output | 1 | Hard configuration capture strobe |
| pcfg_q | output | PCFG_W | Captured power-on configuration |
| hcw_q | output | HCW_W | Captured hard configuration word |

## Verification
The bench changes every input just after a rising edge and samples 1 ns after the next edges. Each expected change therefore falls on a known sample.

| Stimulus | Sample on which the output changes |
|---|---|
| Watchdog, bus-monitor or test-port request | First sample after the stimulus |
| External pin | Third sample (the two earlier samples are checked unchanged) |
| Accepted power-on pulse | Edge 18 after the pin falls |

During a sequence the bench counts, sample by sample, how long each pull-down stays asserted. It then checks the three release samples one by one.

// File: rtl/rst_seq_pkg.sv
// Package: shared types of the reset sequencer.
// Assumes level codes are ordered so that a numeric compare gives priority.
package rst_seq_pkg;

    // Reset level; larger value wins.
    typedef enum logic [1:0] {
        LVL_SOFT = 2'd0,
        LVL_HARD = 2'd1,
        LVL_POR  = 2'd2
    } rst_level_e;

    // Sequencer phase.
    typedef enum logic [1:0] {
        PH_IDLE      = 2'd0,
        PH_HOLD      = 2'd1,
        PH_DROP_HARD = 2'd2,
        PH_DROP_SOFT = 2'd3
    } seq_phase_e;

endpackage

// File: rtl/rst_sync.sv
// Module: rst_sync
// Multi-bit flop-chain synchronizer for independent asynchronous levels.
// Assumes each bit is an unrelated level; no bus coherence is provided.
// Reset loads INIT_VAL so that inactive levels are seen after reset.
module rst_sync #(
    parameter int               WIDTH    = 3,
    parameter int               STAGES   = 2,
    parameter logic [WIDTH-1:0] INIT_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [STAGES-1:0][WIDTH-1:0] chain;

    // Shift each level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= INIT_VAL;
        end else begin
            chain[0] <= d_async;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/rst_por_qual.sv
// Module: rst_por_qual
// Qualifies the synchronized power-on request: it is accepted in the
// MIN_CYC-th consecutive asserted cycle and stays accepted while asserted.
// Assumes MIN_CYC >= 2.
module rst_por_qual #(
    parameter int MIN_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic por_act,     // synchronized, active high
    output logic por_valid
);

    localparam int          CW  = $clog2(MIN_CYC);
    localparam logic [CW-1:0] SAT = CW'(MIN_CYC - 1);

    logic [CW-1:0] run_cnt;

    // Count consecutive asserted cycles, saturating at MIN_CYC-1.
    always_ff @(posedge clk) begin
        if (!rst_n || !por_act) run_cnt <= '0;
        else if (run_cnt != SAT) run_cnt <= run_cnt + 1'b1;
    end

    assign por_valid = por_act && (run_cnt == SAT);

    // An accepted request always had the request asserted a cycle earlier.
    assert_short_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(por_valid) |-> $past(por_act));

endmodule

// File: rtl/rst_seq_fsm.sv
// Module: rst_seq_fsm
// Level arbitration, stretch counter and ordered release. Outputs decode
// the phase and level registers. External pin requests are masked while the
// pin is pulled down and for SYNC_STAGES cycles after, so the controller's
// own drive seen through the synchronizer never re-triggers it.
// Assumes STRETCH_CYC >= 2 and synchronous single-cycle internal events.
module rst_seq_fsm
    import rst_seq_pkg::*;
#(
    parameter int STRETCH_CYC = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic por_valid,
    input  logic hard_lo,       // synchronized hard pin, active high
    input  logic soft_lo,       // synchronized soft pin, active high
    input  logic wdog_hit,
    input  logic bmon_hit,
    input  logic tap_soft,
    output logic hard_pd,
    output logic soft_pd,
    output logic pll_rst_n,
    output logic core_rst_n,
    output logic periph_rst_n,
    output logic pcfg_stb,
    output logic hcw_stb
);

    localparam int            SW   = $clog2(STRETCH_CYC);
    localparam logic [SW-1:0] LOAD = SW'(STRETCH_CYC - 1);

    seq_phase_e           phase;
    rst_level_e           level;
    logic [SW-1:0]        stretch;
    logic [SYNC_STAGES-1:0] hard_hist, soft_hist;

    logic       hard_busy, soft_busy, hard_ext, soft_ext;
    logic       req_any;
    rst_level_e req_lvl;

    // Mask each pin while driven and until its release has crossed the sync.
    always_comb begin
        hard_busy = hard_pd || (|hard_hist);
        soft_busy = (phase != PH_IDLE) || (|soft_hist);
        hard_ext  = hard_lo && !hard_busy;
        soft_ext  = soft_lo && !soft_busy;
    end

    // Pick the highest pending request level.
    always_comb begin
        req_any = 1'b1;
        req_lvl = LVL_SOFT;
        if (por_valid)                         req_lvl = LVL_POR;
        else if (wdog_hit || bmon_hit || hard_ext) req_lvl = LVL_HARD;
        else if (tap_soft || soft_ext)         req_lvl = LVL_SOFT;
        else                                   req_any = 1'b0;
    end

    // Phase, level and stretch counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_HOLD;
            level   <= LVL_POR;
            stretch <= LOAD;
        end else if (req_any && (phase == PH_IDLE || req_lvl > level)) begin
            phase   <= PH_HOLD;
            level   <= req_lvl;
            stretch <= LOAD;
        end else begin
            case (phase)
                PH_HOLD: begin
                    if (level == LVL_POR && por_valid) stretch <= LOAD;
                    else if (stretch == '0)            phase   <= PH_DROP_HARD;
                    else                               stretch <= stretch - 1'b1;
                end
                PH_DROP_HARD: phase <= PH_DROP_SOFT;
                PH_DROP_SOFT: phase <= PH_IDLE;
                default:      phase <= PH_IDLE;
            endcase
        end
    end

    // Remember recent pull-down drive for the re-trigger mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hard_hist <= '1;
            soft_hist <= '1;
        end else begin
            hard_hist[0] <= hard_pd;
            soft_hist[0] <= soft_pd;
            for (int i = 1; i < SYNC_STAGES; i++) begin
                hard_hist[i] <= hard_hist[i-1];
                soft_hist[i] <= soft_hist[i-1];
            end
        end
    end

    // Output decode from phase and level.
    always_comb begin
        hard_pd      = (phase == PH_HOLD) && (level != LVL_SOFT);
        soft_pd      = (phase == PH_HOLD) || (phase == PH_DROP_HARD);
        pll_rst_n    = !((phase == PH_HOLD) && (level == LVL_POR));
        core_rst_n   = (phase == PH_IDLE);
        periph_rst_n = (phase == PH_IDLE) || (level == LVL_SOFT);
        pcfg_stb     = (phase == PH_HOLD) && (level == LVL_POR);
        hcw_stb      = (phase == PH_HOLD) && (level != LVL_SOFT);
    end

    assert_hard_needs_soft_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hard_pd |-> soft_pd);

    assert_hard_before_soft_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hard_pd) |-> (soft_pd && !core_rst_n));

    assert_soft_before_core_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(soft_pd) |-> !core_rst_n);

    assert_pll_por_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_rst_n |-> (!periph_rst_n && hard_pd));

    assert_min_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hard_pd) |=> hard_pd);

endmodule

// File: rtl/reset_sequencer.sv
// Module: reset_sequencer (top)
// Synchronizes the power-on request and both pin levels, qualifies the
// power-on pulse, gates the internal expiry events by their enables,
// sequences the reset levels and captures the two configuration words.
// Assumes expiry and test-port events are already in the clk domain.
module reset_sequencer #(
    parameter int POR_MIN_CYC = 16,
    parameter int STRETCH_CYC = 16,
    parameter int SYNC_STAGES = 2,
    parameter int PCFG_W      = 16,
    parameter int HCW_W       = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_in_n,
    input  logic              hard_pin_in_n,
    input  logic              soft_pin_in_n,
    input  logic              wdog_expire,
    input  logic              wdog_en,
    input  logic              bmon_expire,
    input  logic              bmon_en,
    input  logic              tap_soft_req,
    input  logic [PCFG_W-1:0] pcfg_pins,
    input  logic [HCW_W-1:0]  hcw_in,
    output logic              hard_pin_pd,
    output logic              soft_pin_pd,
    output logic              pll_rst_n,
    output logic              core_rst_n,
    output logic              periph_rst_n,
    output logic              pcfg_stb,
    output logic              hcw_stb,
    output logic [PCFG_W-1:0] pcfg_q,
    output logic [HCW_W-1:0]  hcw_q
);

    logic [2:0] raw_n, sync_n;
    logic       por_valid;

    assign raw_n = {por_in_n, hard_pin_in_n, soft_pin_in_n};

    rst_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .INIT_VAL(3'b111)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (raw_n),
        .q_sync  (sync_n)
    );

    rst_por_qual #(.MIN_CYC(POR_MIN_CYC)) i_por_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .por_act   (!sync_n[2]),
        .por_valid (por_valid)
    );

    rst_seq_fsm #(.STRETCH_CYC(STRETCH_CYC), .SYNC_STAGES(SYNC_STAGES)) i_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .por_valid    (por_valid),
        .hard_lo      (!sync_n[1]),
        .soft_lo      (!sync_n[0]),
        .wdog_hit     (wdog_expire && wdog_en),
        .bmon_hit     (bmon_expire && bmon_en),
        .tap_soft     (tap_soft_req),
        .hard_pd      (hard_pin_pd),
        .soft_pd      (soft_pin_pd),
        .pll_rst_n    (pll_rst_n),
        .core_rst_n   (core_rst_n),
        .periph_rst_n (periph_rst_n),
        .pcfg_stb     (pcfg_stb),
        .hcw_stb      (hcw_stb)
    );

    // Capture the power-on configuration only while its strobe is high.
    always_ff @(posedge clk) begin
        if (!rst_n)        pcfg_q <= '0;
        else if (pcfg_stb) pcfg_q <= pcfg_pins;
    end

    // Capture the hard configuration word while its strobe is high.
    always_ff @(posedge clk) begin
        if (!rst_n)       hcw_q <= '0;
        else if (hcw_stb) hcw_q <= hcw_in;
    end

    assert_pcfg_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !pcfg_stb |=> $stable(pcfg_q));

    assert_hcw_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !hcw_stb |=> $stable(hcw_q));

endmodule

// File: tb/test_reset_sequencer.sv
`timescale 1ns/1ps
module test_reset_sequencer;

    localparam int STRETCH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        por_in_n = 1'b1;
    logic        ext_hard = 1'b0, ext_soft = 1'b0;
    logic        wd_exp = 1'b0, wd_en = 1'b0, bm_exp = 1'b0, bm_en = 1'b0;
    logic        tap_req = 1'b0;
    logic [15:0] pcfg_pins = 16'h0000;
    logic [31:0] hcw_in = 32'h0;
    logic        hard_pd, soft_pd, pll_rst_n, core_rst_n, periph_rst_n;
    logic        pcfg_stb, hcw_stb;
    logic [15:0] pcfg_q;
    logic [31:0] hcw_q;
    logic        hard_pin_n, soft_pin_n;

    int nrun = 0, nfail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    // Open-drain pins: low when the design or the board pulls down.
    assign hard_pin_n = ~(hard_pd | ext_hard);
    assign soft_pin_n = ~(soft_pd | ext_soft);

    reset_sequencer i_reset_sequencer (
        .clk(clk), .rst_n(rst_n), .por_in_n(por_in_n),
        .hard_pin_in_n(hard_pin_n), .soft_pin_in_n(soft_pin_n),
        .wdog_expire(wd_exp), .wdog_en(wd_en),
        .bmon_expire(bm_exp), .bmon_en(bm_en), .tap_soft_req(tap_req),
        .pcfg_pins(pcfg_pins), .hcw_in(hcw_in),
        .hard_pin_pd(hard_pd), .soft_pin_pd(soft_pd), .pll_rst_n(pll_rst_n),
        .core_rst_n(core_rst_n), .periph_rst_n(periph_rst_n),
        .pcfg_stb(pcfg_stb), .hcw_stb(hcw_stb), .pcfg_q(pcfg_q), .hcw_q(hcw_q)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nrun++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 300 && !(core_rst_n === 1'b1); i++) step();
        repeat (6) step();
    endtask

    // Called on the first sample with hard_pd high; measures and checks release.
    task automatic hard_tail(input string tag, input int already);
        int n = already;
        while (hard_pd && n < 200) begin
            step();
            if (hard_pd) n++;
        end
        chk({tag, " R8 hard pin width"}, n, STRETCH);
        chk({tag, " R9 soft held at hard release"}, soft_pd, 1);
        chk({tag, " R9 core held at hard release"}, core_rst_n, 0);
        step();
        chk({tag, " R9 soft released"}, soft_pd, 0);
        chk({tag, " R9 core still held"}, core_rst_n, 0);
        step();
        chk({tag, " R9 core released"}, core_rst_n, 1);
    endtask

    // Called on the first sample with soft_pd high in a soft sequence.
    task automatic soft_tail(input string tag);
        int n = 1;
        while (soft_pd && n < 200) begin
            step();
            if (soft_pd) n++;
        end
        chk({tag, " R8 soft pin width"}, n, STRETCH + 1);
        chk({tag, " R9 core held after soft release"}, core_rst_n, 0);
        step();
        chk({tag, " R9 core released"}, core_rst_n, 1);
    endtask

    task automatic t_reset();
        pcfg_pins = 16'h1111;
        hcw_in    = 32'h0;
        step(); step();
        chk("R12 reset hard pd", hard_pd, 1);
        chk("R12 reset soft pd", soft_pd, 1);
        chk("R12 reset core", core_rst_n, 0);
        chk("R12 reset pll", pll_rst_n, 0);
        rst_n = 1'b1;
        wait_idle();
        chk("R12 released after reset", core_rst_n, 1);
        chk("R12 pll released", pll_rst_n, 1);
    endtask

    task automatic por_pulse(input int len);
        por_in_n = 1'b0;
        repeat (len) step();
        por_in_n = 1'b1;
    endtask

    task automatic t_por_short();
        bit hit = 0;
        por_pulse(15);
        for (int i = 0; i < 40; i++) begin
            step();
            if (core_rst_n !== 1'b1 || soft_pd !== 1'b0) hit = 1;
        end
        chk("R1 15-cycle pulse ignored", hit, 0);
    endtask

    task automatic t_por_long();
        bit hit = 0;
        pcfg_pins = 16'hA5C3;
        hcw_in    = 32'hDEAD_0001;
        por_pulse(16);
        for (int i = 0; i < 10 && !hit; i++) begin
            step();
            if (pll_rst_n === 1'b0) hit = 1;
        end
        chk("R1 16-cycle pulse accepted", hit, 1);
        chk("R2 por hard pd", hard_pd, 1);
        chk("R2 por soft pd", soft_pd, 1);
        chk("R2 por periph", periph_rst_n, 0);
        chk("R2 por core", core_rst_n, 0);
        hard_tail("R2 por", 1);
        wait_idle();
        chk("R3 por config captured", pcfg_q, 32'h0000A5C3);
        chk("R2 hard word captured on por", hcw_q, 32'hDEAD_0001);
    endtask

    task automatic t_wdog();
        pcfg_pins = 16'h0F0F;
        hcw_in    = 32'h1234_5678;
        wd_en = 1'b0; wd_exp = 1'b1;
        step(); wd_exp = 1'b0;
        begin
            bit hit = 0;
            for (int i = 0; i < 20; i++) begin
                if (core_rst_n !== 1'b1) hit = 1;
                step();
            end
            chk("R4 disabled watchdog ignored", hit, 0);
        end
        wd_en = 1'b1; wd_exp = 1'b1;
        step(); wd_exp = 1'b0;
        chk("R11 R4 watchdog next cycle hard pd", hard_pd, 1);
        chk("R4 watchdog periph", periph_rst_n, 0);
        chk("R4 watchdog no pll reset", pll_rst_n, 1);
        hard_tail("R4 watchdog", 1);
        wait_idle();
        chk("R4 hard word recaptured", hcw_q, 32'h1234_5678);
        chk("R3 por config kept over hard", pcfg_q, 32'h0000A5C3);
        wd_en = 1'b0;
    endtask

    task automatic t_bmon();
        bm_en = 1'b1; bm_exp = 1'b1;
        step(); bm_exp = 1'b0;
        chk("R4 bus monitor hard pd", hard_pd, 1);
        hard_tail("R4 bus monitor", 1);
        wait_idle();
        bm_en = 1'b0;
    endtask

    task automatic t_ext_hard();
        hcw_in = 32'h0BAD_F00D;
        ext_hard = 1'b1;
        step();
        chk("R11 ext hard edge1 no change", hard_pd, 0);
        step();
        chk("R11 ext hard edge2 no change", core_rst_n, 1);
        step();
        chk("R11 R4 ext hard edge3 hard pd", hard_pd, 1);
        step(); step();
        ext_hard = 1'b0;
        wait_idle();
        chk("R4 ext hard word captured", hcw_q, 32'h0BAD_F00D);
    endtask

    task automatic t_tap_soft();
        pcfg_pins = 16'h7777;
        hcw_in    = 32'h5555_AAAA;
        tap_req = 1'b1;
        step(); tap_req = 1'b0;
        chk("R6 tap soft pd", soft_pd, 1);
        chk("R6 tap no hard pd", hard_pd, 0);
        chk("R6 tap periph untouched", periph_rst_n, 1);
        chk("R6 tap core reset", core_rst_n, 0);
        soft_tail("R6 tap");
        wait_idle();
        chk("R6 hard word kept", hcw_q, 32'h0BAD_F00D);
        chk("R3 por config kept over soft", pcfg_q, 32'h0000A5C3);
    endtask

    task automatic t_ext_soft();
        bit hit = 0;
        ext_soft = 1'b1;
        step(); step();
        chk("R11 ext soft edge2 no change", soft_pd, 0);
        step();
        chk("R6 ext soft pd", soft_pd, 1);
        step();
        ext_soft = 1'b0;
        wait_idle();
        for (int i = 0; i < 30; i++) begin
            step();
            if (core_rst_n !== 1'b1) hit = 1;
        end
        chk("R7 own release does not retrigger", hit, 0);
    endtask

    task automatic t_priority();
        int n;
        tap_req = 1'b1;
        step(); tap_req = 1'b0;
        repeat (4) step();
        chk("R10 soft seq running", soft_pd, 1);
        wd_en = 1'b1; wd_exp = 1'b1;
        step(); wd_exp = 1'b0; wd_en = 1'b0;
        chk("R10 hard restarts soft seq", hard_pd, 1);
        n = 1;
        repeat (4) begin step(); if (hard_pd) n++; end
        tap_req = 1'b1;
        ext_soft = 1'b1;
        step(); if (hard_pd) n++;
        tap_req = 1'b0;
        step(); if (hard_pd) n++;
        ext_soft = 1'b0;
        hard_tail("R10 lower request ignored", n);
        wait_idle();
    endtask

    initial begin
        t_reset();
        t_por_short();
        t_por_long();
        t_wdog();
        t_bmon();
        t_ext_hard();
        t_tap_soft();
        t_ext_soft();
        t_priority();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", nrun, nfail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            nrun++;
            nfail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", nrun, nfail);
            $finish;
        end
    end

endmodule